// File: doc/BRIEF.md
# Serial Delta-Sigma Result Reader

This block is the master side of a three-wire link to a 16-bit delta-sigma converter. It paces one read per conversion period. For each read it pulls the chip-select line low and toggles a divided serial clock. It captures the data line on every rising clock edge, so a whole code is gathered most significant bit first. The converter has no pipeline latency, so each read returns exactly one conversion. An input multiplexer in front of the converter can therefore switch between reads without any flush reads.

The converter's reference needs time to settle after reset. The block drops the very first completed read after reset. It also drops every read that completes before a startup interval has run out. Results that are kept are converted from offset binary to signed two's complement by inverting the top bit. A flag marks codes that sit at either clamp rail. The result and its flags are published with a one-cycle valid pulse and hold their value until the next pulse.

The read engine is a three-state machine:
- IDLE, with chip select high and the clock low, goes to SHIFT on a period tick. A tick that arrives in any other state is ignored.
- SHIFT drives chip select low and toggles the clock every SCK_DIV/2 system cycles. On the rising edge of the sixteenth bit it goes to DONE.
- DONE raises chip select, parks the clock low, hands the code to the decoder, and always returns to IDLE.

Top module: `sdadc_reader`

## Requirements
- R1: While reset is asserted, `cs_n_o` is 1, `sck_o` is 0, `res_valid_o` is 0, and `res_data_o`, `res_under_o` and `res_over_o` are 0.
- R2: During a read, `cs_n_o` stays low. `sck_o` rises exactly 16 times while `cs_n_o` is low and is never high while `cs_n_o` is high. `sdo_i` is captured on each rising edge, and the first capture is bit 15.
- R3: While `cs_n_o` is low, consecutive rising edges of `sck_o` are SCK_DIV system clock cycles apart.
- R4: The first read that completes after reset never produces a valid pulse, even when the startup interval is zero.
- R5: No valid pulse occurs before STARTUP_US*CLK_PER_US cycles have elapsed since reset. Reads that complete inside that window are dropped.
- R6: Reads start once per conversion period. The period is FAST_US*CLK_PER_US cycles when `rate_slow_i`=0 and SLOW_US*CLK_PER_US cycles when `rate_slow_i`=1. Kept results are therefore spaced exactly one period apart.
- R7: `res_data_o` equals the raw 16-bit code minus 32768, as a signed value. This is the raw code with bit 15 inverted.
- R8: `res_under_o` is 1 exactly when the raw code is 0x0000. `res_over_o` is 1 exactly when the raw code is 0xFFFF. They are never both 1.
- R9: `res_valid_o` is a one-cycle pulse, one clock after `cs_n_o` returns high at the end of a kept read. The data and flag outputs change only on a valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_slow_i | input | 1 | 0 selects the short conversion period, 1 the long one |
| sdo_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select to the converter |
| sck_o | output | 1 | Serial clock to the converter |
| res_valid_o | output | 1 | One-cycle pulse marking a new result |
| res_data_o | output | 16 | Signed result |
| res_under_o | output | 1 | Raw code was at the negative rail |
| res_over_o | output | 1 | Raw code was at the positive rail |

## Verification
A read takes one cycle to lower chip select and SCK_DIV cycles per bit. On the 16th rising clock edge the machine enters DONE. One cycle later chip select rises, and `res_valid_o` follows one further cycle after that. The bench sweeps many codes, including both rails and both sides of mid-scale, through a converter model. The model shifts a new bit after each falling clock edge. The bench samples every output on the falling system clock edge. In the cycle where the valid pulse is seen, the model's read counter has already advanced, so the bench compares against the code for the previous read index. The spacing between pulses is compared with the selected period. After a rate change, the first two spacings are skipped because the period counter carries over its old count.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

    typedef enum logic [1:0] {
        SDR_IDLE  = 2'd0,
        SDR_SHIFT = 2'd1,
        SDR_DONE  = 2'd2
    } sdr_state_e;

endpackage

// File: rtl/sdr_pacer.sv
module sdr_pacer #(
    parameter int STARTUP_CYC = 1500000,
    parameter int FAST_CYC    = 150000,
    parameter int SLOW_CYC    = 600000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rate_slow_i,
    output logic tick_o,
    output logic settled_o
);
    localparam int MAX_CYC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
    localparam int PW      = $clog2(MAX_CYC + 1);
    localparam int SW      = $clog2(STARTUP_CYC + 2);

    logic [PW-1:0] per_q;
    logic [PW-1:0] limit;
    logic [SW-1:0] su_q;

    assign limit     = rate_slow_i ? PW'(SLOW_CYC - 1) : PW'(FAST_CYC - 1);
    assign tick_o    = (per_q >= limit);
    assign settled_o = (su_q == SW'(STARTUP_CYC));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q <= '0;
        end else if (tick_o) begin
            per_q <= '0;
        end else begin
            per_q <= per_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            su_q <= '0;
        end else if (!settled_o) begin
            su_q <= su_q + 1'b1;
        end
    end

endmodule

// File: rtl/sdr_shifter.sv
module sdr_shifter
    import sdr_pkg::*;
#(
    parameter int CODE_W  = 16,
    parameter int SCK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              sdo_i,
    output logic              cs_n_o,
    output logic              sck_o,
    output logic              done_o,
    output logic [CODE_W-1:0] raw_o
);
    localparam int HALF = (SCK_DIV / 2 < 1) ? 1 : SCK_DIV / 2;
    localparam int HW   = $clog2(HALF + 1);
    localparam int BW   = $clog2(CODE_W);

    sdr_state_e        state_q, state_d;
    logic [HW-1:0]     hcnt_q;
    logic [BW-1:0]     bcnt_q;
    logic [CODE_W-1:0] shreg_q;
    logic              half_end;
    logic              last_bit;

    assign half_end = (hcnt_q == HW'(HALF - 1));
    assign last_bit = (bcnt_q == BW'(CODE_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SDR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SDR_IDLE:  if (tick_i) state_d = SDR_SHIFT;
            SDR_SHIFT: if (half_end && !sck_o && last_bit) state_d = SDR_DONE;
            SDR_DONE:  state_d = SDR_IDLE;
            default:   state_d = SDR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_o  <= 1'b1;
            sck_o   <= 1'b0;
            hcnt_q  <= '0;
            bcnt_q  <= '0;
            shreg_q <= '0;
            raw_o   <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                SDR_IDLE: begin
                    if (tick_i) begin
                        cs_n_o <= 1'b0;
                        sck_o  <= 1'b0;
                        hcnt_q <= '0;
                        bcnt_q <= '0;
                    end
                end
                SDR_SHIFT: begin
                    if (half_end) begin
                        hcnt_q <= '0;
                        sck_o  <= ~sck_o;
                        if (!sck_o) begin
                            shreg_q <= {shreg_q[CODE_W-2:0], sdo_i};
                            bcnt_q  <= bcnt_q + 1'b1;
                        end
                    end else begin
                        hcnt_q <= hcnt_q + 1'b1;
                    end
                end
                SDR_DONE: begin
                    cs_n_o <= 1'b1;
                    sck_o  <= 1'b0;
                    raw_o  <= shreg_q;
                    done_o <= 1'b1;
                end
                default: begin
                    cs_n_o <= 1'b1;
                    sck_o  <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/sdr_decode.sv
module sdr_decode #(
    parameter int CODE_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic [CODE_W-1:0]        raw_i,
    output logic                     valid_o,
    output logic signed [CODE_W-1:0] data_o,
    output logic                     under_o,
    output logic                     over_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
            under_o <= 1'b0;
            over_o  <= 1'b0;
        end else begin
            valid_o <= load_i;
            if (load_i) begin
                data_o  <= $signed({~raw_i[CODE_W-1], raw_i[CODE_W-2:0]});
                under_o <= (raw_i == '0);
                over_o  <= (&raw_i);
            end
        end
    end

endmodule

// File: rtl/sdadc_reader.sv
module sdadc_reader #(
    parameter int CLK_PER_US = 125,
    parameter int STARTUP_US = 12000,
    parameter int FAST_US    = 1200,
    parameter int SLOW_US    = 4800,
    parameter int SCK_DIV    = 4,
    parameter int CODE_W     = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rate_slow_i,
    input  logic                     sdo_i,
    output logic                     cs_n_o,
    output logic                     sck_o,
    output logic                     res_valid_o,
    output logic signed [CODE_W-1:0] res_data_o,
    output logic                     res_under_o,
    output logic                     res_over_o
);
    localparam int STARTUP_CYC = STARTUP_US * CLK_PER_US;
    localparam int FAST_CYC    = FAST_US * CLK_PER_US;
    localparam int SLOW_CYC    = SLOW_US * CLK_PER_US;

    logic              tick;
    logic              settled;
    logic              done;
    logic              first_seen_q;
    logic              keep;
    logic [CODE_W-1:0] raw;

    sdr_pacer #(
        .STARTUP_CYC(STARTUP_CYC),
        .FAST_CYC   (FAST_CYC),
        .SLOW_CYC   (SLOW_CYC)
    ) u_pacer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_slow_i(rate_slow_i),
        .tick_o     (tick),
        .settled_o  (settled)
    );

    sdr_shifter #(
        .CODE_W (CODE_W),
        .SCK_DIV(SCK_DIV)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_i(tick),
        .sdo_i (sdo_i),
        .cs_n_o(cs_n_o),
        .sck_o (sck_o),
        .done_o(done),
        .raw_o (raw)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_seen_q <= 1'b0;
        end else if (done) begin
            first_seen_q <= 1'b1;
        end
    end

    assign keep = done && settled && first_seen_q;

    sdr_decode #(
        .CODE_W(CODE_W)
    ) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (keep),
        .raw_i  (raw),
        .valid_o(res_valid_o),
        .data_o (res_data_o),
        .under_o(res_under_o),
        .over_o (res_over_o)
    );

endmodule

// File: rtl/sdadc_reader_chk.sv
module sdadc_reader_chk #(
    parameter int STARTUP_CYC = 0,
    parameter int CODE_W      = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n_o,
    input logic              sck_o,
    input logic              res_valid_o,
    input logic [CODE_W-1:0] res_data_o,
    input logic              res_under_o,
    input logic              res_over_o
);
    logic [31:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst < 32'(STARTUP_CYC)) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    // R2
    sck_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> !cs_n_o);

    // R9
    valid_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> ($past(cs_n_o) && !$past(cs_n_o, 2)));

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid_o |-> ($stable(res_data_o) && $stable(res_under_o) && $stable(res_over_o)));

    // R8
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_under_o && res_over_o));

    // R8
    under_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_under_o) |-> (res_data_o == {1'b1, {(CODE_W-1){1'b0}}}));

    // R8
    over_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_over_o) |-> (res_data_o == {1'b0, {(CODE_W-1){1'b1}}}));

    // R5
    startup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (since_rst >= 32'(STARTUP_CYC)));

endmodule

bind sdadc_reader sdadc_reader_chk #(
    .STARTUP_CYC(STARTUP_CYC),
    .CODE_W     (CODE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_o     (cs_n_o),
    .sck_o      (sck_o),
    .res_valid_o(res_valid_o),
    .res_data_o (res_data_o),
    .res_under_o(res_under_o),
    .res_over_o (res_over_o)
);

// File: tb/sdadc_reader_test.sv
`timescale 1ns/1ps

module sdadc_model (
    input  logic        en,
    input  logic        cs_n,
    input  logic        sck,
    input  logic [15:0] word,
    output logic        sdo,
    output int          reads,
    output int          rises
);
    int idx;
    initial begin
        sdo = 1'b0; reads = 0; rises = 0; idx = 15;
    end
    always @(negedge cs_n) if (en) begin
        idx = 15; rises = 0; sdo = word[15];
    end
    always @(negedge sck) if (en && !cs_n && idx > 0) begin
        idx = idx - 1; sdo = word[idx];
    end
    always @(posedge sck) if (en && !cs_n) rises = rises + 1;
    always @(posedge cs_n) if (en) reads = reads + 1;
endmodule

module sdadc_reader_test;
    localparam int CPU = 2;
    localparam int FAST_C = 25 * CPU;
    localparam int SLOW_C = 40 * CPU;
    localparam int START_C = 95 * CPU;
    localparam int DIV = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, rate_slow;
    logic cs_a, sck_a, sdo_a, val_a, und_a, ovr_a;
    logic cs_b, sck_b, sdo_b, val_b, und_b, ovr_b;
    logic signed [15:0] dat_a, dat_b;
    logic [15:0] word_a, word_b;
    int reads_a, rises_a, reads_b, rises_b;

    int tests = 0, fails = 0, cyc = 0;
    int nva = 0, nvb = 0, last_cyc = -1, skip = 0;
    logic signed [15:0] last_a = '0;
    bit hold_ok = 1'b1, prev_val = 1'b0, finished = 1'b0;
    realtime last_rise = 0.0;

    function automatic logic [15:0] code_of(int k);
        if (k % 37 == 5)       return 16'h0000;
        else if (k % 37 == 11) return 16'hFFFF;
        else if (k % 37 == 17) return 16'h8000;
        else if (k % 37 == 23) return 16'h7FFF;
        else if (k % 37 == 29) return 16'h0001;
        else if (k % 37 == 31) return 16'hFFFE;
        else                   return 16'((k * 2731 + 123) & 16'hFFFF);
    endfunction

    assign word_a = code_of(reads_a);
    assign word_b = code_of(reads_b);

    sdadc_model mdl_a (.en(rst_n), .cs_n(cs_a), .sck(sck_a), .word(word_a),
                       .sdo(sdo_a), .reads(reads_a), .rises(rises_a));
    sdadc_model mdl_b (.en(rst_n), .cs_n(cs_b), .sck(sck_b), .word(word_b),
                       .sdo(sdo_b), .reads(reads_b), .rises(rises_b));

    sdadc_reader #(.CLK_PER_US(CPU), .STARTUP_US(95), .FAST_US(25), .SLOW_US(40),
                   .SCK_DIV(DIV), .CODE_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .rate_slow_i(rate_slow), .sdo_i(sdo_a),
        .cs_n_o(cs_a), .sck_o(sck_a), .res_valid_o(val_a), .res_data_o(dat_a),
        .res_under_o(und_a), .res_over_o(ovr_a));

    sdadc_reader #(.CLK_PER_US(CPU), .STARTUP_US(0), .FAST_US(25), .SLOW_US(40),
                   .SCK_DIV(DIV), .CODE_W(16)) uut2 (
        .clk(clk), .rst_n(rst_n), .rate_slow_i(1'b0), .sdo_i(sdo_b),
        .cs_n_o(cs_b), .sck_o(sck_b), .res_valid_o(val_b), .res_data_o(dat_b),
        .res_under_o(und_b), .res_over_o(ovr_b));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_result(input string tag, input logic signed [15:0] d,
                                input logic u, input logic o, input int k);
        logic [15:0] c;
        int exp_d;
        c = code_of(k);
        exp_d = int'(c) - 32768;
        check(int'(d) == exp_d, {"R7 data ", tag}, int'(d), exp_d);
        check(u == (c == 16'h0000), {"R8 under ", tag}, int'(u), int'(c == 16'h0000));
        check(o == (c == 16'hFFFF), {"R8 over ", tag}, int'(o), int'(c == 16'hFFFF));
    endtask

    // R3: rising sck spacing inside a frame
    always @(posedge sck_a) begin
        if (rst_n && !cs_a) begin
            if (rises_a > 1)
                check(($realtime - last_rise) == real'(DIV * 8), "R3 sck period",
                      int'($realtime - last_rise), DIV * 8);
            last_rise = $realtime;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            cyc++;
            if (val_a) begin
                nva++;
                check_result("A", dat_a, und_a, ovr_a, reads_a - 1);
                // R2: sixteen rising edges per frame, bit 15 first (data match above)
                check(rises_a == 16, "R2 edge count", rises_a, 16);
                // R9: outputs held since the previous pulse, single-cycle pulse
                check(hold_ok && !prev_val, "R9 hold/pulse", int'(hold_ok), 1);
                if (nva == 1) begin
                    // R5: reads 0..2 complete inside the startup window
                    check(reads_a == 4, "R5 first kept read", reads_a, 4);
                    check(cyc >= START_C, "R5 startup window", cyc, START_C);
                end
                if (last_cyc >= 0) begin
                    if (skip > 0) skip--;
                    else check(cyc - last_cyc == (rate_slow ? SLOW_C : FAST_C),
                               "R6 period", cyc - last_cyc, rate_slow ? SLOW_C : FAST_C);
                end
                last_cyc = cyc;
                last_a = dat_a;
                hold_ok = 1'b1;
            end else if (dat_a != last_a) begin
                hold_ok = 1'b0;
            end
            prev_val = val_a;
            if (val_b) begin
                nvb++;
                if (nvb == 1) check(reads_b == 2, "R4 first read dropped", reads_b, 2);
                check_result("B", dat_b, und_b, ovr_b, reads_b - 1);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", nva, 150);
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        rate_slow = 1'b0;
        repeat (5) @(negedge clk);
        // R1: reset state on both instances
        check(cs_a == 1'b1 && cs_b == 1'b1, "R1 cs_n", int'(cs_a), 1);
        check(sck_a == 1'b0 && sck_b == 1'b0, "R1 sck", int'(sck_a), 0);
        check(val_a == 1'b0 && val_b == 1'b0, "R1 valid", int'(val_a), 0);
        check(dat_a == 0 && und_a == 0 && ovr_a == 0, "R1 result", int'(dat_a), 0);
        rst_n = 1'b1;
        wait (nva == 120);
        @(negedge clk);
        rate_slow = 1'b1;
        skip = 2;
        wait (nva == 150);
        @(negedge clk);
        check(nvb > 100, "R6 second instance pacing", nvb, 101);
        finish_run();
    end
endmodule